// File: doc/BRIEF.md
# Segmented Cascaded Clock Divider

This block divides a fast input clock by a ratio made of up to three cascaded segments. The first segment divides by 2 or by 3. The second and third segments each divide by 2, 4, 6 or 8. A one-hot path-select code sets how many segments form the cascade: the first alone, the first two, or all three. The product of the active ratios runs from 2 to 192, so the cascade can reach 2, 3, 4, 6, 8, 12, 16, 24, 32, 36, 48, 64, 96, 128 and 192, plus the other legal products.

Every segment runs in the input clock domain. Each segment passes an advance pulse to the next one, so the output never passes through a clock made by the logic. The divide-by-3 segment adds one flop on the falling edge of the input clock, so the divided output keeps a 50% duty cycle. A segment that is switched off or not selected is held cleared and is stepped around. A bad code mutes the output and raises an error flag.

The configuration inputs pass through one register stage before they act. A change of configuration or enable therefore takes effect on the second rising edge of the input clock.

Top module: `seg_clk_divider`

## Requirements
- R1: With the first segment the only one in the path, `s1Odd`=0 gives a `clkOut` period of 2 input cycles and `s1Odd`=1 gives 3 input cycles.
- R2: The ratio codes of segments 2 and 3 map 4'b0001 to divide-by-2, 4'b0010 to divide-by-4, 4'b0100 to divide-by-6 and 4'b1000 to divide-by-8. Code 4'b0000 switches the segment off.
- R3: `pathSel` 3'b001 selects segment 1 only, 3'b010 selects segments 1 and 2, and 3'b100 selects segments 1, 2 and 3. With 3'b000, `clkOut` stays low and `cfgError` stays low.
- R4: The `clkOut` period equals the product of the ratios of the active segments in the path, from 2 up to 192 (3×8×8).
- R5: `clkOut` is high for exactly half of its period. For divide-by-3 this is 1.5 input cycles.
- R6: While `divEn` is low, `clkOut` is low and every segment counter is cleared. After `divEn` rises, the first output pulse already has the full programmed width.
- R7: A segment 2 or 3 that is selected but has its enable low, or has code 0, is stepped around. It adds no factor to the ratio and its counter stays cleared.
- R8: With `s1En` low, `clkOut` stays low, whatever the other segments are set to.
- R9: A ratio code on segment 2 or 3 that is not 0, 1, 2, 4 or 8, or a `pathSel` of 3, 5, 6 or 7, sets `cfgError` high and holds `clkOut` low. This applies whatever the enables and the selection are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock to be divided |
| rstN | input | 1 | Asynchronous active-low reset |
| divEn | input | 1 | Global enable of the whole divider |
| s1En | input | 1 | Segment 1 enable |
| s1Odd | input | 1 | Segment 1 ratio: 0 gives /2, 1 gives /3 |
| s2En | input | 1 | Segment 2 enable |
| s2Code | input | 4 | Segment 2 one-hot ratio code |
| s3En | input | 1 | Segment 3 enable |
| s3Code | input | 4 | Segment 3 one-hot ratio code |
| pathSel | input | 3 | One-hot number of cascaded segments |
| clkOut | output | 1 | Divided clock |
| cfgError | output | 1 | Illegal code detected |

## Verification
Two functions can act in the same cycle. One is the muting of the output by an illegal code. The other is the stepping around of a segment that is off. Both come from the same registered decode, so they take effect on the same edge.

The bench provokes the overlap with configurations that carry a bad code on an unselected or disabled segment. Such a setting would otherwise be stepped around, but instead it must raise `cfgError` and leave `clkOut` low. In the other direction, the bench sets a segment that is stepped around with a legal code and checks that the error flag stays clear. A second overlap occurs when segment 1 runs in divide-by-3 mode and feeds segment 2 or 3. The falling-edge flop shapes the output pulse while the next segment counts on the rising edge. The bench measures the high time and the period at half-cycle sample points to judge both results.

// File: rtl/seg_div_pkg.sv
`timescale 1ns/1ps
package seg_div_pkg;
  localparam int CODE_W = 4;
  localparam int SEL_W  = 3;
  localparam int HALF_W = $clog2(CODE_W + 1);

  typedef struct packed {
    logic              s1Run;
    logic              s1Odd;
    logic              s2Run;
    logic              s3Run;
    logic [HALF_W-1:0] s2Half;
    logic [HALF_W-1:0] s3Half;
    logic [1:0]        tapSel;
    logic              err;
  } div_ctrl_t;

  function automatic logic codeLegal(input logic [CODE_W-1:0] c);
    return (c == '0) || ($countones(c) == 1);
  endfunction

  // one-hot bit k means divide by 2*(k+1): half count k+1
  function automatic logic [HALF_W-1:0] codeToHalf(input logic [CODE_W-1:0] c);
    logic [HALF_W-1:0] h;
    h = '0;
    for (int k = 0; k < CODE_W; k++)
      if (c == CODE_W'(1 << k)) h = HALF_W'(k + 1);
    return h;
  endfunction
endpackage

// File: rtl/seg_div_ctrl.sv
`timescale 1ns/1ps
module seg_div_ctrl
  import seg_div_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              divEn,
  input  logic              s1En,
  input  logic              s1Odd,
  input  logic              s2En,
  input  logic [CODE_W-1:0] s2Code,
  input  logic              s3En,
  input  logic [CODE_W-1:0] s3Code,
  input  logic [SEL_W-1:0]  pathSel,
  output div_ctrl_t         ctrl
);
  div_ctrl_t nextCtrl;
  logic selLegal, active, useS2, useS3;

  always_comb begin
    selLegal = ($countones(pathSel) <= 1);
    useS2    = pathSel[1] | pathSel[2];
    useS3    = pathSel[2];
    nextCtrl = '0;
    nextCtrl.err    = !selLegal || !codeLegal(s2Code) || !codeLegal(s3Code);
    active          = divEn && s1En && !nextCtrl.err && (pathSel != '0);
    nextCtrl.s1Run  = active;
    nextCtrl.s1Odd  = s1Odd;
    nextCtrl.s2Run  = active && useS2 && s2En && (s2Code != '0);
    nextCtrl.s3Run  = active && useS3 && s3En && (s3Code != '0);
    nextCtrl.s2Half = codeToHalf(s2Code);
    nextCtrl.s3Half = codeToHalf(s3Code);
    nextCtrl.tapSel = useS3 ? 2'd2 : (useS2 ? 2'd1 : 2'd0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctrl <= '0;
    else       ctrl <= nextCtrl;
  end
endmodule

// File: rtl/seg_div_first.sv
`timescale 1ns/1ps
module seg_div_first (
  input  logic clk,
  input  logic rstN,
  input  logic run,
  input  logic odd,
  output logic lvl,
  output logic tickOut
);
  logic [1:0] cnt;
  logic tgl, posHigh, negHigh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0; tgl <= 1'b0; posHigh <= 1'b0;
    end else if (!run) begin
      cnt <= '0; tgl <= 1'b0; posHigh <= 1'b0;
    end else if (odd) begin
      cnt     <= (cnt == 2'd2) ? 2'd0 : cnt + 2'd1;
      posHigh <= (cnt == 2'd2);
      tgl     <= 1'b0;
    end else begin
      cnt     <= '0;
      posHigh <= 1'b0;
      tgl     <= ~tgl;
    end
  end

  // half-cycle extension of the single-cycle pulse for 50% duty at /3
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) negHigh <= 1'b0;
    else       negHigh <= posHigh && run && odd;
  end

  assign lvl     = odd ? (posHigh | negHigh) : tgl;
  assign tickOut = run && (odd ? (cnt == 2'd2) : !tgl);

  a_r5_single_cycle_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (run && odd && posHigh) |=> !posHigh);
  a_r1_even_tick_alternates: assert property (@(posedge clk) disable iff (!rstN)
    (run && !odd && tickOut) |=> !tickOut);
endmodule

// File: rtl/seg_div_even.sv
`timescale 1ns/1ps
module seg_div_even #(
  parameter int HW = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          run,
  input  logic [HW-1:0] half,
  input  logic          tickIn,
  output logic          lvl,
  output logic          tickOut
);
  logic [HW-1:0] cnt;
  logic wrap;

  assign wrap = (cnt == half - HW'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0; lvl <= 1'b0;
    end else if (!run) begin
      cnt <= '0; lvl <= 1'b0;
    end else if (tickIn) begin
      if (wrap) begin
        cnt <= '0;
        lvl <= ~lvl;
      end else begin
        cnt <= cnt + HW'(1);
      end
    end
  end

  assign tickOut = run && tickIn && wrap && !lvl;

  a_r6_idle_cleared: assert property (@(posedge clk) disable iff (!rstN)
    !run |=> (cnt == '0 && !lvl));
  a_r2_hold_between_ticks: assert property (@(posedge clk) disable iff (!rstN)
    (run && !tickIn) |=> $stable(lvl));
endmodule

// File: rtl/seg_div_path.sv
`timescale 1ns/1ps
module seg_div_path
  import seg_div_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  div_ctrl_t ctrl,
  output logic      clkOut
);
  localparam int N_SEG = 3;
  logic [N_SEG-1:0] chainLvl, chainTick;
  logic tapLvl;

  seg_div_first u_first (
    .clk(clk), .rstN(rstN), .run(ctrl.s1Run), .odd(ctrl.s1Odd),
    .lvl(chainLvl[0]), .tickOut(chainTick[0])
  );

  for (genvar g = 1; g < N_SEG; g++) begin : g_even
    logic segRun, ownLvl, ownTick;
    logic [HALF_W-1:0] segHalf;
    assign segRun  = (g == 1) ? ctrl.s2Run  : ctrl.s3Run;
    assign segHalf = (g == 1) ? ctrl.s2Half : ctrl.s3Half;
    seg_div_even #(.HW(HALF_W)) u_seg (
      .clk(clk), .rstN(rstN), .run(segRun), .half(segHalf),
      .tickIn(chainTick[g-1]), .lvl(ownLvl), .tickOut(ownTick)
    );
    // a stopped segment is stepped around
    assign chainLvl[g]  = segRun ? ownLvl  : chainLvl[g-1];
    assign chainTick[g] = segRun ? ownTick : chainTick[g-1];
  end

  always_comb begin
    case (ctrl.tapSel)
      2'd1:    tapLvl = chainLvl[1];
      2'd2:    tapLvl = chainLvl[2];
      default: tapLvl = chainLvl[0];
    endcase
  end

  assign clkOut = ctrl.s1Run && !ctrl.err && tapLvl;
endmodule

// File: rtl/seg_clk_divider.sv
`timescale 1ns/1ps
module seg_clk_divider
  import seg_div_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              divEn,
  input  logic              s1En,
  input  logic              s1Odd,
  input  logic              s2En,
  input  logic [CODE_W-1:0] s2Code,
  input  logic              s3En,
  input  logic [CODE_W-1:0] s3Code,
  input  logic [SEL_W-1:0]  pathSel,
  output logic              clkOut,
  output logic              cfgError
);
  div_ctrl_t ctrl;

  seg_div_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .divEn(divEn), .s1En(s1En), .s1Odd(s1Odd),
    .s2En(s2En), .s2Code(s2Code), .s3En(s3En), .s3Code(s3Code),
    .pathSel(pathSel), .ctrl(ctrl)
  );

  seg_div_path u_path (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .clkOut(clkOut)
  );

  assign cfgError = ctrl.err;

  a_r9_error_mutes_output: assert property (@(posedge clk) disable iff (!rstN)
    cfgError |-> !clkOut);
  a_r8_idle_first_mutes: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.s1Run && !$past(ctrl.s1Run)) |-> !clkOut);
endmodule

// File: tb/seg_clk_divider_test.sv
`timescale 1ns/1ps
module seg_clk_divider_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic divEn = 0, s1En = 0, s1Odd = 0, s2En = 0, s3En = 0;
  logic [3:0] s2Code = '0, s3Code = '0;
  logic [2:0] pathSel = '0;
  logic clkOut, cfgError;
  int nChecks = 0, nFail = 0;

  always #5 clk = ~clk;

  seg_clk_divider uut (
    .clk(clk), .rstN(rstN), .divEn(divEn), .s1En(s1En), .s1Odd(s1Odd),
    .s2En(s2En), .s2Code(s2Code), .s3En(s3En), .s3Code(s3Code),
    .pathSel(pathSel), .clkOut(clkOut), .cfgError(cfgError)
  );

  typedef struct packed {
    logic       en, e1, o1, e2;
    logic [3:0] c2;
    logic       e3;
    logic [3:0] c3;
    logic [2:0] sel;
    logic [7:0] expN;   // 0: output must stay low
    logic       expErr;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1,1,0,0,4'd0,0,4'd0,3'd1,8'd2,  0,4'd1},  // R1 /2
    '{1,1,1,0,4'd0,0,4'd0,3'd1,8'd3,  0,4'd1},  // R1 /3
    '{1,1,1,1,4'd8,1,4'd8,3'd4,8'd192,0,4'd4},  // R4 maximum
    '{1,1,0,0,4'd4,1,4'd2,3'd4,8'd8,  0,4'd7},  // R7 seg2 enable low
    '{1,1,1,1,4'd0,1,4'd4,3'd4,8'd18, 0,4'd7},  // R7 seg2 code 0
    '{1,1,0,1,4'd8,0,4'd8,3'd4,8'd16, 0,4'd7},  // R7 seg3 enable low
    '{1,1,0,1,4'd8,1,4'd8,3'd2,8'd16, 0,4'd3},  // R3 seg3 not selected
    '{1,1,0,1,4'd2,1,4'd2,3'd0,8'd0,  0,4'd3},  // R3 select 0
    '{1,0,0,1,4'd2,1,4'd2,3'd4,8'd0,  0,4'd8},  // R8 seg1 off
    '{0,1,0,1,4'd2,1,4'd2,3'd4,8'd0,  0,4'd6},  // R6 global off
    '{1,1,0,1,4'd3,1,4'd2,3'd4,8'd0,  1,4'd9},  // R9 bad seg2 code
    '{1,1,0,1,4'd2,1,4'd2,3'd6,8'd0,  1,4'd9},  // R9 bad select
    '{1,1,0,1,4'd2,0,4'd9,3'd1,8'd0,  1,4'd9},  // R9 bad code, unused segment
    '{0,1,0,1,4'd2,1,4'd5,3'd1,8'd0,  1,4'd9}   // R9 bad code while disabled
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic apply(input logic en, e1, o1, e2, input logic [3:0] c2,
                       input logic e3, input logic [3:0] c3, input logic [2:0] sel);
    @(posedge clk); #2;
    divEn = 1'b0;
    repeat (4) @(posedge clk);
    #2;
    s1En = e1; s1Odd = o1; s2En = e2; s2Code = c2; s3En = e3; s3Code = c3;
    pathSel = sel; divEn = en;
  endtask

  // half-cycle samples; returns period and first high time in half cycles
  task automatic measure(output int perH, output int highH);
    logic prev, cur;
    bit found, done, inHigh;
    perH = -1; highH = -1; found = 0; done = 0; inHigh = 1;
    @(posedge clk); #2;
    prev = clkOut;
    for (int i = 0; i < 1000 && !found; i++) begin
      #5; cur = clkOut;
      if (!prev && cur) found = 1;
      prev = cur;
    end
    if (!found) return;
    perH = 1; highH = 1;
    for (int i = 0; i < 1000 && !done; i++) begin
      #5; cur = clkOut;
      if (!prev && cur) done = 1;
      else begin
        perH++;
        if (cur && inHigh) highH++;
        else inHigh = 0;
      end
      prev = cur;
    end
    if (!done) perH = -1;
  endtask

  task automatic expectLow(input string tag, input int halves);
    int highs = 0;
    repeat (3) @(posedge clk);
    #2;
    for (int i = 0; i < halves; i++) begin
      if (clkOut) highs++;
      #5;
    end
    check(highs == 0, tag, highs, 0);
  endtask

  task automatic runRatio(input string tag, input int n);
    int perH, highH;
    measure(perH, highH);
    check(perH == 2 * n, {tag, " period"}, perH / 2, n);
    check(highH == n, {"R5 duty ", tag}, highH, n);
  endtask

  initial begin
    #2_000_000;
    nFail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    int perH, highH, n;
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    repeat (2) @(posedge clk);
    #2;
    check(clkOut == 1'b0, "reset clkOut", clkOut, 0);
    check(cfgError == 1'b0, "reset cfgError", cfgError, 0);

    for (int v = 0; v < NV; v++) begin
      string tag;
      tag = $sformatf("R%0d row %0d", VECS[v].req, v);
      apply(VECS[v].en, VECS[v].e1, VECS[v].o1, VECS[v].e2, VECS[v].c2,
            VECS[v].e3, VECS[v].c3, VECS[v].sel);
      if (VECS[v].expN != 0) runRatio(tag, int'(VECS[v].expN));
      else expectLow(tag, 200);
      check(cfgError == VECS[v].expErr, {tag, " cfgError"}, cfgError, VECS[v].expErr);
    end

    // R4 R2: every legal cascade
    for (int o = 0; o < 2; o++)
      for (int s = 0; s < 3; s++)
        for (int a = 0; a < 4; a++)
          for (int b = 0; b < 4; b++) begin
            if (s == 0 && (a != 0 || b != 0)) continue;
            if (s == 1 && b != 0) continue;
            n = (o != 0) ? 3 : 2;
            if (s >= 1) n = n * 2 * (a + 1);
            if (s == 2) n = n * 2 * (b + 1);
            apply(1, 1, o[0], 1, 4'(1 << a), 1, 4'(1 << b), 3'(1 << s));
            runRatio($sformatf("R4 R2 o%0d s%0d a%0d b%0d", o, s, a, b), n);
          end

    // R6: disable while running forces low
    apply(1, 1, 0, 0, 4'd0, 0, 4'd0, 3'd1);
    repeat (10) @(posedge clk);
    #2 divEn = 1'b0;
    expectLow("R6 disable mid-run", 100);

    // R6: first pulse after enable has full width (/24)
    apply(1, 1, 1, 1, 4'd2, 1, 4'd1, 3'd4);
    measure(perH, highH);
    check(highH == 24, "R6 first pulse width", highH, 24);
    check(perH == 48, "R6 first period", perH / 2, 24);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule